// File: doc/BRIEF.md
# Cell Header Connection-Identifier Extractor

This block sits on a byte-wide cell stream, one byte per clock, where a cell-start strobe marks the first header byte of every cell slot. While the five header bytes pass by, a byte counter steers per-byte load strobes. These strobes pick the 8-bit path identifier and the 16-bit channel identifier out of the user-side header layout into holding registers. A five-stage register pipeline keeps a copy of the whole header. Payload bytes that follow the header are not looked at.

The captured identifier is not passed on at once. It waits until the next cell-start strobe. On that strobe the block samples an external header-good flag, which upstream header checking drives. If the flag is high and the previous slot delivered all five header bytes, the block copies the identifier and the header into output registers. It also raises a one-cycle availability pulse for a downstream connection search. Header checking, the payload path and any table lookup are outside this block.

Top module: `cellIdExtract`

## Requirements
- R1: After reset, idAvail is 0 and idOut and hdrOut are all zeros.
- R2: A released identifier is idOut = {byte0[3:0], byte1[7:4], byte1[3:0], byte2[7:0], byte3[7:4]}. Byte 0 is the byte present with cellStart. Bits 23:16 hold the path identifier and bits 15:0 hold the channel identifier.
- R3: idAvail is high for exactly one cycle. It is the cycle after the clock edge that samples cellStart high with a complete previous header and hdrOk high.
- R4: hdrOk is sampled only on the cellStart cycle. When it is low there, no pulse follows and idOut and hdrOut keep their values. Its value in any other cycle has no effect.
- R5: Bytes at positions 5 and above after cellStart (payload) do not change the released identifier or header.
- R6: When cellStart comes back before five header bytes of the current cell have been received (a runt cell), the next slot boundary gives no pulse and no output change.
- R7: The first cellStart after reset gives no pulse, because no header has been captured yet.
- R8: A released hdrOut holds byte0 in bits 39:32, then byte1 in bits 31:24, and so on down to byte4 in bits 7:0.
- R9: idOut and hdrOut change only in the cycle where idAvail is high.
- R10: Back-to-back five-byte cells, with cellStart every fifth cycle, each release their own header correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cellStart | input | 1 | High with the first header byte of a cell |
| byteIn | input | 8 | Cell stream byte |
| hdrOk | input | 1 | Header-good flag for the previous cell, sampled on cellStart |
| idAvail | output | 1 | One-cycle pulse: a new identifier is available |
| idOut | output | 24 | Released path and channel identifier |
| hdrOut | output | 40 | Released five-byte header |

## Verification
The hardest case to reach is a slot boundary where the capture registers hold a mix of two cells. This happens after a runt cell, or right after reset, when only part of the header bytes have been overwritten. The stimulus sends a full cell with good status, then a two-byte runt, then another cell. The check is that the runt's boundary stays silent and that the outputs still show the earlier header. Back-to-back five-byte cells push the counter to its shortest period. The hdrOk line is also driven opposite to its meaningful value on every non-start cycle, which shows it is sampled only on the boundary.

// File: rtl/cidPkg.sv
package cidPkg;
  localparam int BYTE_W    = 8;
  localparam int HDR_BYTES = 5;
  localparam int VPI_W     = 8;
  localparam int VCI_W     = 16;
  localparam int ID_W      = VPI_W + VCI_W;
  localparam int HDR_W     = BYTE_W * HDR_BYTES;
  localparam int CNT_W     = $clog2(HDR_BYTES + 1);

  typedef struct packed {
    logic                 pipeShift;
    logic                 slotRelease;
    logic [HDR_BYTES-1:0] capLoad;
  } ctlStrobes_t;
endpackage

// File: rtl/cidControl.sv
module cidControl
  import cidPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cellStart,
  input  logic        hdrOk,
  output ctlStrobes_t strb
);
  logic [CNT_W-1:0] byteCnt;
  logic [CNT_W-1:0] curIdx;
  logic             inHeader;
  logic             hdrDone;
  logic [HDR_BYTES-1:0] loadVec;

  // index of the byte on byteIn this cycle; a start strobe forces zero
  always_comb begin
    curIdx   = cellStart ? '0 : byteCnt;
    inHeader = cellStart || (byteCnt < CNT_W'(HDR_BYTES));
  end

  for (genvar k = 0; k < HDR_BYTES; k++) begin : gLoad
    assign loadVec[k] = inHeader && (curIdx == CNT_W'(k));
  end

  always_comb begin
    strb.capLoad     = loadVec;
    strb.pipeShift   = inHeader;
    strb.slotRelease = cellStart && hdrDone && hdrOk;
  end

  // counter parks at HDR_BYTES so nothing is captured before the first start
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteCnt <= CNT_W'(HDR_BYTES);
    end else if (cellStart) begin
      byteCnt <= CNT_W'(1);
    end else if (byteCnt < CNT_W'(HDR_BYTES)) begin
      byteCnt <= byteCnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hdrDone <= 1'b0;
    end else if (cellStart) begin
      hdrDone <= 1'b0;
    end else if (loadVec[HDR_BYTES-1]) begin
      hdrDone <= 1'b1;
    end
  end
endmodule

// File: rtl/cidDatapath.sv
module cidDatapath
  import cidPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [BYTE_W-1:0] byteIn,
  input  ctlStrobes_t       strb,
  output logic              idAvail,
  output logic [ID_W-1:0]   idOut,
  output logic [HDR_W-1:0]  hdrOut
);
  logic [BYTE_W-1:0] pipeStage [HDR_BYTES];
  logic [HDR_W-1:0]  hdrCat;
  logic [VPI_W-1:0]  vpiReg;
  logic [VCI_W-1:0]  vciReg;

  // header pipeline: stage 0 takes the newest byte
  for (genvar k = 0; k < HDR_BYTES; k++) begin : gPipe
    if (k == 0) begin : gHead
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)               pipeStage[k] <= '0;
        else if (strb.pipeShift) pipeStage[k] <= byteIn;
      end
    end else begin : gBody
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)               pipeStage[k] <= '0;
        else if (strb.pipeShift) pipeStage[k] <= pipeStage[k-1];
      end
    end
    assign hdrCat[(k+1)*BYTE_W-1 -: BYTE_W] = pipeStage[k];
  end

  // identifier field capture, one strobe per header byte
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vpiReg <= '0;
      vciReg <= '0;
    end else begin
      if (strb.capLoad[0]) vpiReg[7:4]   <= byteIn[3:0];
      if (strb.capLoad[1]) begin
        vpiReg[3:0]   <= byteIn[7:4];
        vciReg[15:12] <= byteIn[3:0];
      end
      if (strb.capLoad[2]) vciReg[11:4]  <= byteIn;
      if (strb.capLoad[3]) vciReg[3:0]   <= byteIn[7:4];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idAvail <= 1'b0;
      idOut   <= '0;
      hdrOut  <= '0;
    end else begin
      idAvail <= strb.slotRelease;
      if (strb.slotRelease) begin
        idOut  <= {vpiReg, vciReg};
        hdrOut <= hdrCat;
      end
    end
  end
endmodule

// File: rtl/cellIdExtract.sv
module cellIdExtract
  import cidPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cellStart,
  input  logic [BYTE_W-1:0] byteIn,
  input  logic              hdrOk,
  output logic              idAvail,
  output logic [ID_W-1:0]   idOut,
  output logic [HDR_W-1:0]  hdrOut
);
  ctlStrobes_t strb;

  cidControl uCtl (
    .clk       (clk),
    .rstN      (rstN),
    .cellStart (cellStart),
    .hdrOk     (hdrOk),
    .strb      (strb)
  );

  cidDatapath uDp (
    .clk     (clk),
    .rstN    (rstN),
    .byteIn  (byteIn),
    .strb    (strb),
    .idAvail (idAvail),
    .idOut   (idOut),
    .hdrOut  (hdrOut)
  );
endmodule

// File: rtl/cellIdExtractChecker.sv
module cellIdExtractChecker
  import cidPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              cellStart,
  input logic              hdrOk,
  input logic              idAvail,
  input logic [ID_W-1:0]   idOut,
  input logic [HDR_W-1:0]  hdrOut
);
  logic [2:0] runLen;
  logic [1:0] startSeen;

  // cycles since the last start strobe, inclusive, saturating at 7
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runLen    <= '0;
      startSeen <= '0;
    end else begin
      if (cellStart)          runLen <= 3'd1;
      else if (runLen != 3'd7 && runLen != 3'd0) runLen <= runLen + 3'd1;
      if (cellStart && startSeen != 2'd2) startSeen <= startSeen + 2'd1;
    end
  end

  assert_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    idAvail |=> !idAvail);

  assert_gate_R4: assert property (@(posedge clk) disable iff (!rstN)
    idAvail |-> $past(cellStart && hdrOk));

  assert_full_hdr_R6: assert property (@(posedge clk) disable iff (!rstN)
    idAvail |-> ($past(runLen) >= 3'd5));

  assert_first_start_R7: assert property (@(posedge clk) disable iff (!rstN)
    idAvail |-> (startSeen == 2'd2));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !idAvail |-> ($stable(idOut) && $stable(hdrOut)));
endmodule

bind cellIdExtract cellIdExtractChecker uChk (
  .clk       (clk),
  .rstN      (rstN),
  .cellStart (cellStart),
  .hdrOk     (hdrOk),
  .idAvail   (idAvail),
  .idOut     (idOut),
  .hdrOut    (hdrOut)
);

// File: tb/sim_cellIdExtract.sv
module sim_cellIdExtract;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cellStart = 1'b0;
  logic [7:0]  byteIn = '0;
  logic        hdrOk = 1'b0;
  logic        idAvail;
  logic [23:0] idOut;
  logic [39:0] hdrOut;

  int checks = 0;
  int errors = 0;

  // bench model
  logic [39:0] prevHdr;
  bit          prevComplete;
  logic [23:0] expId;
  logic [39:0] expHdr;

  always #(CLK_PERIOD/2) clk = ~clk;

  cellIdExtract u0 (
    .clk(clk), .rstN(rstN), .cellStart(cellStart), .byteIn(byteIn),
    .hdrOk(hdrOk), .idAvail(idAvail), .idOut(idOut), .hdrOut(hdrOut)
  );

  task automatic check(input bit ok, input string req, input logic [39:0] act,
                       input logic [39:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] idOf(input logic [39:0] h);
    logic [7:0] b0, b1, b2, b3;
    b0 = h[39:32]; b1 = h[31:24]; b2 = h[23:16]; b3 = h[15:8];
    return {b0[3:0], b1[7:4], b1[3:0], b2, b3[7:4]};
  endfunction

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; cellStart = 1'b0; byteIn = '0; hdrOk = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    prevComplete = 0; expId = '0; expHdr = '0; prevHdr = '0;
  endtask

  // sends one cell of nBytes; okPrev is the status given for the previous cell
  task automatic sendCell(input logic [39:0] hdr, input int nBytes,
                          input bit okPrev, input string req);
    bit expAvail;
    expAvail = prevComplete && okPrev;
    for (int i = 0; i < nBytes; i++) begin
      @(negedge clk);
      if (i == 1) begin
        check(idAvail == expAvail, {req, " pulse"}, 40'(idAvail), 40'(expAvail));
        if (expAvail) begin
          expId  = idOf(prevHdr);
          expHdr = prevHdr;
        end
        check(idOut == expId, {req, " id"}, 40'(idOut), 40'(expId));
        check(hdrOut == expHdr, {req, " R8 hdr"}, hdrOut, expHdr);
      end
      if (i == 2) begin
        check(idAvail == 1'b0, {req, " R3 width"}, 40'(idAvail), 40'd0);
        check(idOut == expId, {req, " R9 hold"}, 40'(idOut), 40'(expId));
      end
      cellStart = (i == 0);
      hdrOk     = (i == 0) ? okPrev : ~okPrev;
      byteIn    = (i < 5) ? hdr[39 - 8*i -: 8] : (8'(i * 29) ^ hdr[7:0]);
    end
    prevHdr      = hdr;
    prevComplete = (nBytes >= 5);
  endtask

  task automatic testReset();
    doReset();
    @(negedge clk);
    check(idAvail == 1'b0, "R1 avail", 40'(idAvail), 40'd0);
    check(idOut == '0, "R1 id", 40'(idOut), 40'd0);
    check(hdrOut == '0, "R1 hdr", hdrOut, 40'd0);
  endtask

  task automatic testBasic();
    sendCell(40'h0A_BC_DE_F2_55, 53, 1'b1, "R7 first");
    sendCell(40'h05_A3_C7_E1_11, 53, 1'b1, "R2 basic");
    sendCell(40'hF0_0F_FF_00_22, 53, 1'b1, "R2 pattern");
    sendCell(40'h3C_96_5A_69_33, 20, 1'b1, "R2 alt");
  endtask

  task automatic testBadHeader();
    sendCell(40'h12_34_56_78_9A, 53, 1'b1, "R4 pre");
    sendCell(40'h0F_FF_FF_F0_44, 53, 1'b0, "R4 bad");
    sendCell(40'h01_23_45_67_89, 10, 1'b0, "R4 bad2");
    sendCell(40'h77_88_99_AA_BB, 10, 1'b1, "R4 good");
  endtask

  task automatic testRunt();
    sendCell(40'h09_87_65_43_21, 12, 1'b1, "R6 pre");
    sendCell(40'h0E_EE_EE_E0_00, 2, 1'b1, "R6 runt");
    sendCell(40'h06_66_66_60_00, 4, 1'b1, "R6 runt4");
    sendCell(40'h02_46_8A_CE_01, 8, 1'b1, "R6 after");
    sendCell(40'h0B_DF_13_57_02, 8, 1'b1, "R6 recover");
  endtask

  task automatic testPayload();
    sendCell(40'h0C_AF_E0_B0_77, 53, 1'b1, "R5 long");
    sendCell(40'h00_00_00_00_00, 53, 1'b1, "R5 zero");
    sendCell(40'hFF_FF_FF_FF_FF, 9, 1'b1, "R5 ones");
  endtask

  task automatic testBackToBack();
    for (int c = 0; c < 6; c++) begin
      sendCell({8'(c * 17), 8'(c * 53 + 1), 8'(c * 91 + 7), 8'(c * 13 + 200), 8'(c)},
               5, 1'b1, "R10 b2b");
    end
    sendCell(40'h01_02_03_04_05, 5, 1'b1, "R10 flush");
  endtask

  task automatic testRestart();
    doReset();
    sendCell(40'h0D_0D_0D_0D_0D, 6, 1'b1, "R7 restart");
    sendCell(40'h0E_0E_0E_0E_0E, 6, 1'b1, "R7 second");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    testReset();
    testBasic();
    testBadHeader();
    testRunt();
    testPayload();
    testBackToBack();
    testRestart();
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule